// File: doc/BRIEF.md
# Registered Adder-Subtractor with Status Flags

This block adds or subtracts two integers of a parameterized width on a single adder datapath. When the mode input asks for subtraction, the second operand is inverted bit by bit and a carry-in of one enters the least significant position. The adder therefore forms A + ~B + 1, the two's complement difference. The result bits are the same whether the caller treats the operands as signed or unsigned. Only the flags differ in meaning.

The sum and six status flags are captured in output registers on the rising clock edge. The flags are the raw carry out of the top bit, a borrow indication, a single unsigned-overflow flag that works in both modes, a signed-overflow flag, a negative flag and a zero flag. A caller doing unsigned arithmetic reads the unsigned-overflow or borrow flag. A caller doing signed arithmetic reads the signed-overflow and negative flags. The datapath can be built as an explicit ripple chain or as a plain vector addition, chosen by a parameter.

Top module: `addsub_flags_unit`

## Requirements
- R1: While `rst` is high at a rising edge, every output register is cleared to 0 at that edge.
- R2: Outputs are registered. The values seen after a rising edge belong to the inputs sampled at that edge, so the latency is one cycle.
- R3: With `sub_mode` = 0 (add), `sum_q` is (A + B) mod 2^WIDTH and `carry_q` is 1 exactly when A + B ≥ 2^WIDTH.
- R4: With `sub_mode` = 1 (subtract), `sum_q` is (A − B) mod 2^WIDTH and `carry_q` is 1 exactly when A ≥ B as unsigned numbers.
- R5: `borrow_q` is the inverse of `carry_q` in subtract mode and is 0 in add mode.
- R6: `uovf_q` equals `carry_q` XOR the mode bit. It is 1 on an unsigned add that overflows and on an unsigned subtract with A < B.
- R7: `sovf_q` is 1 when the two's complement result does not fit in WIDTH bits. For add, this happens when A and B have the same sign and the result sign differs from it. For subtract, it happens when A and B differ in sign and the result sign differs from the sign of A.
- R8: `neg_q` equals bit WIDTH−1 of `sum_q`.
- R9: `zero_q` is 1 exactly when every bit of `sum_q` is 0.
- R10: Subtracting zero (B = 0, `sub_mode` = 1) gives `carry_q` = 1, `borrow_q` = 0 and `uovf_q` = 0 for every A.
- R11: At WIDTH = 4, computing 7 − 3 gives `sum_q` = 4'b0100 with `carry_q` = 1, `uovf_q` = 0 and `sovf_q` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| sum_q | output | WIDTH | Registered result bits |
| carry_q | output | 1 | Raw carry out of the top adder bit |
| borrow_q | output | 1 | Unsigned borrow, subtract mode only |
| uovf_q | output | 1 | Unsigned overflow/underflow for either mode |
| sovf_q | output | 1 | Two's complement overflow |
| neg_q | output | 1 | Sign bit of the result |
| zero_q | output | 1 | Result is all zeros |

## Verification
The properties compare each output with the operands and the mode sampled one edge earlier. They therefore assume that `op_a`, `op_b` and `sub_mode` carry known values at every rising edge outside reset, and that reset is held for at least one edge before checking starts. The stimulus holds reset for several edges at start-up. It changes inputs only on the falling edge and always to defined values. It covers every operand pair at width 4 and random pairs at width 8, plus directed sign-boundary and zero-subtrahend cases.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_mode_e;

  typedef struct packed {
    logic carry;
    logic borrow;
    logic uovf;
    logic sovf;
    logic neg;
    logic zero;
  } status_t;

  localparam status_t STATUS_CLEAR = '{default: 1'b0};

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_in,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] b_eff,
  output logic             cin
);
  import addsub_pkg::*;

  op_mode_e mode;

  always_comb begin
    mode = op_mode_e'(sub_mode);
  end

  // Conditional inversion: one XOR per bit selects B or ~B.
  for (genvar i = 0; i < WIDTH; i++) begin : g_inv
    assign b_eff[i] = b_in[i] ^ (mode == OP_SUB);
  end

  // The +1 of the two's complement enters as the carry-in.
  assign cin = (mode == OP_SUB);

endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int WIDTH      = 8,
  parameter bit USE_RIPPLE = 1'b1
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_into_msb,
  output logic             c_out
);
  localparam int MSB = WIDTH - 1;

  if (USE_RIPPLE) begin : g_ripple
    logic [WIDTH:0] chain;
    assign chain[0] = cin;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic p, g;
      assign p          = a_in[i] ^ b_in[i];
      assign g          = a_in[i] & b_in[i];
      assign sum[i]     = p ^ chain[i];
      assign chain[i+1] = g | (p & chain[i]);
    end
    assign c_into_msb = chain[MSB];
    assign c_out      = chain[WIDTH];
  end else begin : g_vector
    logic [WIDTH:0] wide;
    always_comb begin
      wide = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, cin};
    end
    assign sum        = wide[MSB:0];
    assign c_out      = wide[WIDTH];
    // The carry into the top bit is recovered from that bit's sum.
    assign c_into_msb = wide[MSB] ^ a_in[MSB] ^ b_in[MSB];
  end

endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]      sum,
  input  logic                  c_into_msb,
  input  logic                  c_out,
  input  logic                  sub_mode,
  output addsub_pkg::status_t   status
);
  import addsub_pkg::*;

  localparam int MSB = WIDTH - 1;

  always_comb begin
    status        = STATUS_CLEAR;
    status.carry  = c_out;
    // In subtract mode the carry out means "no borrow".
    status.borrow = sub_mode & ~c_out;
    // One flag for both modes: add overflows on carry,
    // subtract underflows on no carry.
    status.uovf   = c_out ^ sub_mode;
    status.sovf   = c_into_msb ^ c_out;
    status.neg    = sum[MSB];
    status.zero   = ~|sum;
  end

endmodule

// File: rtl/addsub_flags_unit.sv
module addsub_flags_unit #(
  parameter int WIDTH      = 8,
  parameter bit USE_RIPPLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] sum_q,
  output logic             carry_q,
  output logic             borrow_q,
  output logic             uovf_q,
  output logic             sovf_q,
  output logic             neg_q,
  output logic             zero_q
);
  import addsub_pkg::*;

  logic [WIDTH-1:0] b_eff;
  logic             cin;
  logic [WIDTH-1:0] sum_d;
  logic             c_into_msb;
  logic             c_out;
  status_t          status_d;
  status_t          status_r;

  addsub_operand_prep #(.WIDTH(WIDTH)) prep_i (
    .b_in     (op_b),
    .sub_mode (sub_mode),
    .b_eff    (b_eff),
    .cin      (cin)
  );

  addsub_core #(.WIDTH(WIDTH), .USE_RIPPLE(USE_RIPPLE)) core_i (
    .a_in       (op_a),
    .b_in       (b_eff),
    .cin        (cin),
    .sum        (sum_d),
    .c_into_msb (c_into_msb),
    .c_out      (c_out)
  );

  addsub_flag_gen #(.WIDTH(WIDTH)) flags_i (
    .sum        (sum_d),
    .c_into_msb (c_into_msb),
    .c_out      (c_out),
    .sub_mode   (sub_mode),
    .status     (status_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q    <= '0;
      status_r <= STATUS_CLEAR;
    end else begin
      sum_q    <= sum_d;
      status_r <= status_d;
    end
  end

  assign carry_q  = status_r.carry;
  assign borrow_q = status_r.borrow;
  assign uovf_q   = status_r.uovf;
  assign sovf_q   = status_r.sovf;
  assign neg_q    = status_r.neg;
  assign zero_q   = status_r.zero;

endmodule

// File: rtl/addsub_flags_unit_chk.sv
module addsub_flags_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             sub_mode,
  input logic [WIDTH-1:0] sum_q,
  input logic             carry_q,
  input logic             borrow_q,
  input logic             uovf_q,
  input logic             sovf_q,
  input logic             neg_q,
  input logic             zero_q
);
  localparam int MSB = WIDTH - 1;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sum_q == '0) && !carry_q && !borrow_q && !uovf_q
            && !sovf_q && !neg_q && !zero_q);

  p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
    !sub_mode |=> sum_q == $past(op_a + op_b));

  p_sub_sum_r4: assert property (@(posedge clk) disable iff (rst)
    sub_mode |=> (sum_q == $past(op_a - op_b))
                 && (carry_q == ($past(op_a) >= $past(op_b))));

  p_borrow_add_r5: assert property (@(posedge clk) disable iff (rst)
    !sub_mode |=> !borrow_q);

  p_borrow_sub_r5: assert property (@(posedge clk) disable iff (rst)
    sub_mode |=> borrow_q != carry_q);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> uovf_q == (carry_q ^ $past(sub_mode)));

  p_signed_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sovf_q == (($past(op_a[MSB]) == ($past(op_b[MSB]) ^ $past(sub_mode)))
                        && (sum_q[MSB] != $past(op_a[MSB]))));

  p_neg_zero_r8_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (neg_q == sum_q[MSB]) && (zero_q == (sum_q == '0)));

  p_sub_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (sub_mode && op_b == '0) |=> carry_q && !borrow_q && !uovf_q);

endmodule

bind addsub_flags_unit addsub_flags_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .op_a     (op_a),
  .op_b     (op_b),
  .sub_mode (sub_mode),
  .sum_q    (sum_q),
  .carry_q  (carry_q),
  .borrow_q (borrow_q),
  .uovf_q   (uovf_q),
  .sovf_q   (sovf_q),
  .neg_q    (neg_q),
  .zero_q   (zero_q)
);

// File: tb/addsub_flags_unit_tb_top.sv
module addsub_flags_unit_tb_top;

  typedef struct packed {
    logic [15:0] s;
    logic        c, bo, u, v, n, z;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] a8 = '0, b8 = '0;
  logic       m8 = 1'b0;
  logic [7:0] s8;
  logic       c8, bo8, u8, v8, n8, z8;

  logic [3:0] a4 = '0, b4 = '0;
  logic       m4 = 1'b0;
  logic [3:0] s4;
  logic       c4, bo4, u4, v4, n4, z4;

  addsub_flags_unit #(.WIDTH(8), .USE_RIPPLE(1'b1)) dut_i (
    .clk(clk), .rst(rst), .op_a(a8), .op_b(b8), .sub_mode(m8),
    .sum_q(s8), .carry_q(c8), .borrow_q(bo8), .uovf_q(u8),
    .sovf_q(v8), .neg_q(n8), .zero_q(z8));

  addsub_flags_unit #(.WIDTH(4), .USE_RIPPLE(1'b0)) dut4_i (
    .clk(clk), .rst(rst), .op_a(a4), .op_b(b4), .sub_mode(m4),
    .sum_q(s4), .carry_q(c4), .borrow_q(bo4), .uovf_q(u4),
    .sovf_q(v4), .neg_q(n4), .zero_q(z4));

  // Behavioural reference in plain integers.
  function automatic exp_t ref_calc(int w, int a, int b, bit sub);
    exp_t e;
    int mod  = 1 << w;
    int half = mod / 2;
    int full, res, sa, sb, sr;
    if (!sub) begin
      full = a + b;
      res  = full % mod;
      e.c  = (full >= mod);
      e.u  = (full >= mod);
    end else begin
      res  = (a - b + mod) % mod;
      e.c  = (a >= b);
      e.u  = (a < b);
    end
    e.bo = sub && (a < b);
    sa   = (a >= half) ? a - mod : a;
    sb   = (b >= half) ? b - mod : b;
    sr   = sub ? sa - sb : sa + sb;
    e.v  = (sr > half - 1) || (sr < -half);
    e.n  = (res >= half);
    e.z  = (res == 0);
    e.s  = 16'(res);
    return e;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(exp_t e, exp_t g, bit sub);
    check(sub ? "R4 sum" : "R3 sum", int'(g.s), int'(e.s));
    check(sub ? "R4 carry" : "R3 carry", int'(g.c), int'(e.c));
    check("R5 borrow", int'(g.bo), int'(e.bo));
    check("R6 unsigned ovf", int'(g.u), int'(e.u));
    check("R7 signed ovf", int'(g.v), int'(e.v));
    check("R8 negative", int'(g.n), int'(e.n));
    check("R9 zero", int'(g.z), int'(e.z));
  endtask

  // Inputs change at the falling edge; results are read one falling edge later (R2).
  task automatic run8(int a, int b, bit sub);
    exp_t g;
    @(negedge clk);
    a8 = 8'(a); b8 = 8'(b); m8 = sub;
    @(negedge clk);
    g = '{s: 16'(s8), c: c8, bo: bo8, u: u8, v: v8, n: n8, z: z8};
    compare(ref_calc(8, a, b, sub), g, sub);
  endtask

  task automatic run4(int a, int b, bit sub);
    exp_t g;
    @(negedge clk);
    a4 = 4'(a); b4 = 4'(b); m4 = sub;
    @(negedge clk);
    g = '{s: 16'(s4), c: c4, bo: bo4, u: u4, v: v4, n: n4, z: z4};
    compare(ref_calc(4, a, b, sub), g, sub);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset dominates nonzero inputs.
    a8 = 8'hFF; b8 = 8'h01; m8 = 1'b0;
    a4 = 4'hF;  b4 = 4'h1;  m4 = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset sum8", int'(s8), 0);
    check("R1 reset flags8", int'({c8, bo8, u8, v8, n8, z8}), 0);
    check("R1 reset sum4", int'(s4), 0);
    check("R1 reset flags4", int'({c4, bo4, u4, v4, n4, z4}), 0);
    @(negedge clk);
    rst = 1'b0;

    // R11: 7 - 3 at width 4.
    @(negedge clk);
    a4 = 4'd7; b4 = 4'd3; m4 = 1'b1;
    @(negedge clk);
    check("R11 sum", int'(s4), 4);
    check("R11 carry", int'(c4), 1);
    check("R11 uovf", int'(u4), 0);
    check("R11 sovf", int'(v4), 0);

    // Exhaustive width 4, both modes.
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run4(a, b, bit'(m));

    // R10: subtracting zero at width 8.
    for (int a = 0; a < 256; a += 17) begin
      @(negedge clk);
      a8 = 8'(a); b8 = 8'd0; m8 = 1'b1;
      @(negedge clk);
      check("R10 carry", int'(c8), 1);
      check("R10 borrow", int'(bo8), 0);
      check("R10 uovf", int'(u8), 0);
    end

    // Sign and wrap boundaries at width 8.
    run8(8'h7F, 8'h01, 1'b0);
    run8(8'h80, 8'h01, 1'b1);
    run8(8'hFF, 8'h01, 1'b0);
    run8(8'h00, 8'h01, 1'b1);
    run8(8'h80, 8'h80, 1'b0);
    run8(8'h00, 8'h80, 1'b1);
    run8(8'h55, 8'h55, 1'b1);

    // Random width 8.
    for (int i = 0; i < 3000; i++)
      run8(int'($urandom_range(255)), int'($urandom_range(255)), bit'($urandom_range(1)));

    // R1: reset taken mid-run clears outputs at the next edge.
    @(negedge clk);
    a8 = 8'hF0; b8 = 8'h20; m8 = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset sum8", int'(s8), 0);
    check("R1 mid-run reset flags8", int'({c8, bo8, u8, v8, n8, z8}), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule